// File: doc/BRIEF.md
# RS-485 Driver-Enable Controller

This block steers the direction pin of an RS-485 transceiver that sits behind a UART transmitter. The UART core reports through a busy flag that it is sending. That flag covers the span from the first start bit to the end of the final stop bit, and it stays high while more data waits in the transmit path. The controller turns this flag into a driver-enable level that rises in the same cycle as the flag.

After the flag drops, the controller keeps the transceiver driving for a programmable number of bit periods, so the far end sees a clean line turnaround. The bit periods are counted on a one-cycle tick from the baud generator. A single 12-bit configuration word sets four things: whether automatic control is on, which output pin carries it, the active polarity, and the hold time.

When automatic control is off, the modem RTS output simply mirrors the RTS bit written by software. The dedicated enable pin then stays low.

Top module: `rs485_de_ctrl`

## Requirements
- R1: Configuration word layout: bit 0 turns on automatic direction control, bit 1 routes it to `rts_o` (1) or `de_o` (0), bit 2 is polarity, and bits 11:8 hold the after-send hold time in bit periods (0 to 15). All other bits are ignored.
- R2: With polarity 0 the routed pin is high while active and low while inactive. With polarity 1 both levels are inverted.
- R3: The routed pin becomes active in the same cycle that `tx_busy_i` rises, with no lead delay. It stays active for as long as `tx_busy_i` stays high, so back-to-back frames give one unbroken active period.
- R4: With a hold time of 0, the routed pin goes inactive in the first cycle in which `tx_busy_i` is low.
- R5: With a hold time N > 0, the routed pin stays active through the cycle in which `tx_busy_i` falls. It also stays active until N `bit_tick_i` pulses have been counted. Only pulses in later cycles where `tx_busy_i` is low are counted. The pin goes inactive in the cycle after the Nth counted pulse.
- R6: If `tx_busy_i` rises again during a hold, the hold is cancelled, the pin stays active without a gap, and the next fall starts a fresh full hold.
- R7: With the enable bit clear, `rts_o` equals `sw_rts_i` and `de_o` is low, and any hold in progress is discarded.
- R8: With the enable bit set, the pin that is not selected is left alone. When control goes to `rts_o`, `de_o` is low. When control goes to `de_o`, `rts_o` equals `sw_rts_i`.
- R9: The hold time is captured when `tx_busy_i` falls. A change to bits 11:8 during a hold does not change that hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 12 | Configuration word (enable, routing, polarity, hold time) |
| bit_tick_i | input | 1 | One-cycle pulse per bit period from the baud generator |
| tx_busy_i | input | 1 | Transmitter busy (frame in flight or data pending) |
| sw_rts_i | input | 1 | Software-written modem RTS bit |
| rts_o | output | 1 | Modem RTS pin, or the direction control when routed here |
| de_o | output | 1 | Dedicated driver-enable pin |

## Verification
If the hold counter held a wrong value, the routed pin would release at the wrong time after a frame. This shows at the ports on the first bit tick where the count differs, within at most 15 bit periods of the busy fall.

A lost busy history would show in the cycle of the fall itself, as a one-cycle dropout when a hold is configured.

A stale hold that survives a disable or a new frame would show as a release that comes too late, or as a gap between back-to-back frames.

The reference model checks both pins on every cycle. It drives both polarities, both routings, hold times of 0, 1, 3 and 15, cancelled holds and a hold-time change in mid-hold.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;
  localparam int CFG_W = 12;
  localparam int DLY_W = 4;

  typedef struct packed {
    logic [DLY_W-1:0]       dly;
    logic [CFG_W-DLY_W-4:0] rsvd;
    logic                   pol;
    logic                   on_rts;
    logic                   en;
  } de_cfg_t;
endpackage

// File: rtl/rs485_hold_timer.sv
module rs485_hold_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             busy_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             active_o
);
  logic             busy_q;
  logic [DLY_W-1:0] cnt_q;
  logic             fall;
  logic             dly_nz;

  assign dly_nz = |dly_i;
  assign fall   = busy_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_i;
      if (!en_i || busy_i)           cnt_q <= '0;
      else if (fall)                 cnt_q <= dly_i;  // hold time captured here
      else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  // fall cycle covered combinationally so the pin has no one-cycle dropout
  assign active_o = busy_i | (cnt_q != '0) | (fall & dly_nz);
endmodule

// File: rtl/rs485_pin_mux.sv
module rs485_pin_mux (
  input  logic en_i,
  input  logic on_rts_i,
  input  logic pol_i,
  input  logic active_i,
  input  logic sw_rts_i,
  output logic rts_o,
  output logic de_o
);
  logic level;

  assign level = active_i ^ pol_i;

  always_comb begin
    rts_o = sw_rts_i;
    de_o  = 1'b0;
    if (en_i) begin
      if (on_rts_i) rts_o = level;
      else          de_o  = level;
    end
  end
endmodule

// File: rtl/rs485_de_ctrl.sv
module rs485_de_ctrl
  import rs485_de_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             bit_tick_i,
  input  logic             tx_busy_i,
  input  logic             sw_rts_i,
  output logic             rts_o,
  output logic             de_o
);
  de_cfg_t cfg;
  logic    active;

  assign cfg = de_cfg_t'(cfg_i);

  rs485_hold_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cfg.en),
    .busy_i   (tx_busy_i),
    .tick_i   (bit_tick_i),
    .dly_i    (cfg.dly),
    .active_o (active)
  );

  rs485_pin_mux u_mux (
    .en_i     (cfg.en),
    .on_rts_i (cfg.on_rts),
    .pol_i    (cfg.pol),
    .active_i (active),
    .sw_rts_i (sw_rts_i),
    .rts_o    (rts_o),
    .de_o     (de_o)
  );
endmodule

// File: rtl/rs485_de_ctrl_chk.sv
module rs485_de_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [11:0] cfg_i,
  input logic        bit_tick_i,
  input logic        tx_busy_i,
  input logic        sw_rts_i,
  input logic        rts_o,
  input logic        de_o
);
  logic en, on_rts, pol, dly_nz;
  assign en     = cfg_i[0];
  assign on_rts = cfg_i[1];
  assign pol    = cfg_i[2];
  assign dly_nz = |cfg_i[11:8];

  p_start_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && on_rts && tx_busy_i) |-> (rts_o == !pol));

  p_zero_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !on_rts && !dly_nz && !tx_busy_i && $past(tx_busy_i)) |-> (de_o == pol));

  p_hold_fall_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !on_rts && dly_nz && !tx_busy_i && $past(tx_busy_i)) |-> (de_o == !pol));

  p_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (rts_o == sw_rts_i && !de_o));

  p_unrouted_de_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && on_rts) |-> !de_o);

  p_unrouted_rts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !on_rts) |-> (rts_o == sw_rts_i));
endmodule

bind rs485_de_ctrl rs485_de_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_i      (cfg_i),
  .bit_tick_i (bit_tick_i),
  .tx_busy_i  (tx_busy_i),
  .sw_rts_i   (sw_rts_i),
  .rts_o      (rts_o),
  .de_o       (de_o)
);

// File: tb/rs485_de_ctrl_tb.sv
module rs485_de_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg = '0;
  logic        tick = 1'b0;
  logic        busy = 1'b0;
  logic        sw_rts = 1'b0;
  logic        rts, de;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string phase = "R7";

  // reference state
  int m_cnt = 0;
  bit m_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_de_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .bit_tick_i(tick),
    .tx_busy_i(busy), .sw_rts_i(sw_rts), .rts_o(rts), .de_o(de)
  );

  // free-running bit tick, changed just after each edge
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #1;
      div = (div + 1) % TICK_DIV;
      tick = (div == 0);
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  = 0;
      m_prev = 0;
    end else begin
      if (!cfg[0] || busy)                  m_cnt = 0;
      else if (m_prev && cfg[11:8] != 0)   m_cnt = int'(cfg[11:8]);
      else if (tick && m_cnt > 0)          m_cnt = m_cnt - 1;
      m_prev = busy;
    end
  end

  always @(negedge clk) begin
    bit act, lvl, e_rts, e_de;
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      act = busy || m_cnt > 0 || (m_prev && !busy && cfg[11:8] != 0);
      lvl = act ^ cfg[2];
      e_rts = sw_rts; e_de = 1'b0;
      if (cfg[0]) begin
        if (cfg[1]) e_rts = lvl; else e_de = lvl;
      end
      checks++;
      if (rts !== e_rts || de !== e_de) begin
        errors++;
        $display("FAIL %s t=%0t rts_o=%b de_o=%b expected rts_o=%b de_o=%b",
                 phase, $time, rts, de, e_rts, e_de);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame(int len, int gap);
    busy = 1'b1; step(len);
    busy = 1'b0; step(gap);
  endtask

  initial begin
    step(3);
    // reset state: all low
    checks++;
    if (rts !== 1'b0 || de !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset rts_o=%b de_o=%b expected 0 0", rts, de);
    end
    rst_n = 1'b1; step(2);

    phase = "R7"; // disabled: rts mirrors software bit
    sw_rts = 1'b1; frame(10, 5); sw_rts = 1'b0; frame(6, 5);

    phase = "R3"; cfg = 12'h303; frame(12, 40);
    phase = "R2"; cfg = 12'h307; frame(12, 40);
    phase = "R8"; cfg = 12'h301; sw_rts = 1'b1; frame(9, 40);
    cfg = 12'h305; frame(9, 40); sw_rts = 1'b0;
    phase = "R1"; cfg = 12'h1F9; frame(7, 20);   // reserved bits set
    phase = "R4"; cfg = 12'h001; frame(8, 6);
    cfg = 12'h007; frame(8, 6);
    phase = "R5"; cfg = 12'hF01; frame(5, 80);
    cfg = 12'h103; frame(5, 12);
    phase = "R3"; cfg = 12'h201; frame(5, 0); frame(5, 0); frame(5, 20);
    phase = "R6"; cfg = 12'h601; frame(6, 7); frame(6, 40);
    phase = "R9"; cfg = 12'h501; frame(6, 3); cfg = 12'h101; step(40);
    phase = "R7"; cfg = 12'hF01; frame(6, 4); cfg = 12'hF00; step(4);
    cfg = 12'hF01; step(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule